// File: doc/BRIEF.md
# Access Check and Fault Status Register

This block is the permission stage of a paged memory management unit. Once a table walk has located the final page entry, the walk logic presents three inputs to this block: the entry's 3-bit permission code, the entry's modified bit, and the attributes of the access (write, instruction fetch, supervisor). In the same cycle the block decides whether the access is allowed. If it is, the block produces the read/write/execute set to be cached for the page. If it is not, it either raises a trap request or, when no-fault mode is set or traps are disabled, grants the access with full rights.

Faults are recorded in a fault status register and a fault address register, and software reads both. The status register keeps the access kind, the error type and a valid flag. A second fault that arrives before software has read the first one sets an overflow flag. Reading the status register clears it.

Top module: `mmu_access_guard`

## Requirements
- R1: The access index is 3 bits: bit 2 is write, bit 1 is instruction fetch and bit 0 is supervisor. On a recorded fault the index is stored in status bits 7:5.
- R2: The permission codes map to rights as follows. User access: code 0 is R, 1 is RW, 2 is RX, 3 is RWX, 4 is X only, 5 is R, and 6 and 7 give no rights. Supervisor access: codes 0 to 4 are the same, 5 is RW, 6 is RX and 7 is RWX. The right needed by an access is W for a write, X for a fetch, and R when the access is neither. If a needed right is missing, the error is a protection error with value 8.
- R3: A user access under code 6 or 7 gives a privilege error with value 12, whatever kind of access it is.
- R4: A granted access drives `perm_o` with bit 0 = read, bit 1 = write and bit 2 = execute, taken from the R2 rights for its privilege level.
- R5: While `modified_i` is 0, the write bit of a normally granted permission set is forced to 0.
- R6: A recorded fault writes the status register as follows: bit 1 is set, bits 3:2 take error bits 3:2 (2'b10 for a protection error, 2'b11 for a privilege error), and bits 7:5 take the index. Bit 0 (overflow) is set when the status register held a nonzero value that was not read in the same cycle.
- R7: A recorded fault loads the fault address register with `vaddr_i`, with its low PAGE_BITS bits cleared. In every other cycle the register holds its value.
- R8: A faulting access does not trap when no-fault mode or disabled traps apply. It is granted with `perm_o` = 3'b111, and the fault is still recorded.
- R9: In no-fault mode, a user access with an error is treated as allowed. It is granted with the R4/R5 rights, it does not trap, and neither register changes.
- R10: A fault that is not covered by R8 or R9 withholds the grant and raises exactly one trap request: `trap_inst_o` for a fetch, `trap_data_o` otherwise.
- R11: `fsr_o` always shows the status register. Asserting `fsr_rd_i` clears the register at the clock edge. A fault recorded in the same cycle as a read is written without the overflow flag.
- R12: After reset, the status and address registers are 0.
- R13: While `req_valid_i` is 0, `grant_o`, `perm_o` and both trap outputs are 0, and the registers change only through a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | A page entry is presented for checking |
| acc_write_i | input | 1 | Access is a write |
| acc_fetch_i | input | 1 | Access is an instruction fetch |
| acc_super_i | input | 1 | Access is made in supervisor mode |
| perm_code_i | input | 3 | Permission code of the page entry |
| modified_i | input | 1 | Modified bit of the page entry |
| vaddr_i | input | ADDR_W | Virtual address of the access |
| no_fault_i | input | 1 | No-fault mode enable |
| traps_en_i | input | 1 | Processor trap enable |
| fsr_rd_i | input | 1 | Software read of the status register (clears it) |
| grant_o | output | 1 | Access may proceed |
| perm_o | output | 3 | Rights to cache: bit 0 R, bit 1 W, bit 2 X |
| trap_inst_o | output | 1 | Instruction-access fault trap request |
| trap_data_o | output | 1 | Data-access fault trap request |
| fsr_o | output | 8 | Fault status register |
| far_o | output | ADDR_W | Fault address register |

## Verification
The two functions that can fall in the same cycle are the software read-and-clear of the status register and the recording of a new fault. A sweep over every combination of index, code, modified bit, no-fault mode and trap enable asserts the read on every third step while faults keep arriving, and directed steps also place a fault directly on a read. The bench's own model treats the read value as consumed, so a fault on a read cycle is expected without the overflow flag and a fault on the following cycle is expected with it.

// File: rtl/mmu_acc_pkg.sv
`timescale 1ns/1ps
package mmu_acc_pkg;
  localparam int FSR_W       = 8;
  localparam int FSR_OVF     = 0;
  localparam int FSR_VLD     = 1;
  localparam int FSR_ERR_LSB = 2;
  localparam int FSR_IDX_LSB = 5;

  localparam int PERM_R = 0;
  localparam int PERM_W = 1;
  localparam int PERM_X = 2;

  localparam logic [3:0] ERR_NONE = 4'd0;
  localparam logic [3:0] ERR_PROT = 4'd8;
  localparam logic [3:0] ERR_PRIV = 4'd12;

  // packed order is the access index
  typedef struct packed {
    logic write;
    logic fetch;
    logic sup;
  } acc_idx_t;

  function automatic logic [2:0] base_perm(input logic [2:0] code, input logic sup);
    logic [2:0] p;
    case (code)
      3'd0: p = 3'b001;
      3'd1: p = 3'b011;
      3'd2: p = 3'b101;
      3'd3: p = 3'b111;
      3'd4: p = 3'b100;
      3'd5: p = sup ? 3'b011 : 3'b001;
      3'd6: p = sup ? 3'b101 : 3'b000;
      default: p = sup ? 3'b111 : 3'b000;
    endcase
    return p;
  endfunction
endpackage

// File: rtl/acc_perm_decode.sv
`timescale 1ns/1ps
module acc_perm_decode
  import mmu_acc_pkg::*;
#(
  parameter int CODE_W = 3
) (
  input  acc_idx_t          idx_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [3:0]        err_o,
  output logic [2:0]        rights_o
);
  localparam int NCODE = 1 << CODE_W;

  logic [2:0] usr_tbl [NCODE];
  logic [2:0] sup_tbl [NCODE];

  for (genvar g = 0; g < NCODE; g++) begin : g_tbl
    assign usr_tbl[g] = base_perm(3'(g), 1'b0);
    assign sup_tbl[g] = base_perm(3'(g), 1'b1);
  end

  logic [2:0] need;
  logic       priv_hit;

  always_comb begin
    rights_o       = idx_i.sup ? sup_tbl[code_i] : usr_tbl[code_i];
    need           = '0;
    need[PERM_W]   = idx_i.write;
    need[PERM_X]   = idx_i.fetch;
    need[PERM_R]   = !idx_i.write && !idx_i.fetch;
    priv_hit       = !idx_i.sup && (code_i[CODE_W-1:CODE_W-2] == 2'b11);
    if (priv_hit)                      err_o = ERR_PRIV;
    else if ((need & ~rights_o) != '0) err_o = ERR_PROT;
    else                               err_o = ERR_NONE;
  end
endmodule

// File: rtl/acc_fault_ctrl.sv
`timescale 1ns/1ps
module acc_fault_ctrl
  import mmu_acc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_valid_i,
  input  acc_idx_t   idx_i,
  input  logic [3:0] err_i,
  input  logic [2:0] rights_i,
  input  logic       modified_i,
  input  logic       no_fault_i,
  input  logic       traps_en_i,
  output logic       upd_o,
  output logic       grant_o,
  output logic [2:0] perm_o,
  output logic       trap_inst_o,
  output logic       trap_data_o
);
  logic has_err, suppress, override, trap;
  logic [2:0] masked;

  always_comb begin
    has_err  = (err_i != ERR_NONE);
    // user error in no-fault mode never reaches the status register
    suppress = no_fault_i && !idx_i.sup && has_err;
    upd_o    = req_valid_i && has_err && !suppress;
    override = upd_o && (no_fault_i || !traps_en_i);
    trap     = upd_o && !override;
    grant_o  = req_valid_i && !trap;

    masked         = rights_i;
    masked[PERM_W] = rights_i[PERM_W] && modified_i;

    if (!grant_o)      perm_o = '0;
    else if (override) perm_o = 3'b111;
    else               perm_o = masked;

    trap_inst_o = trap && idx_i.fetch;
    trap_data_o = trap && !idx_i.fetch;
  end

  p_one_trap_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({trap_inst_o, trap_data_o}) && !((trap_inst_o || trap_data_o) && grant_o));

  p_wmask_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o && !modified_i && !upd_o) |-> !perm_o[PERM_W]);

  p_override_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o && upd_o) |-> (perm_o == 3'b111));
endmodule

// File: rtl/acc_fault_regs.sv
`timescale 1ns/1ps
module acc_fault_regs
  import mmu_acc_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_i,
  input  logic              rd_i,
  input  acc_idx_t          idx_i,
  input  logic [3:0]        err_i,
  input  logic [ADDR_W-1:0] vaddr_i,
  output logic [FSR_W-1:0]  fsr_o,
  output logic [ADDR_W-1:0] far_o
);
  localparam logic [ADDR_W-1:0] PAGE_MASK = ~((ADDR_W'(1) << PAGE_BITS) - ADDR_W'(1));

  logic [FSR_W-1:0]  fsr_q, fsr_d, base, entry;
  logic [ADDR_W-1:0] far_q;

  always_comb begin
    base  = rd_i ? '0 : fsr_q;
    entry = '0;
    entry[FSR_OVF]              = (base != '0);
    entry[FSR_VLD]              = 1'b1;
    entry[FSR_ERR_LSB +: 2]     = err_i[3:2];
    entry[FSR_IDX_LSB +: 3]     = idx_i;
    fsr_d = upd_i ? entry : base;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fsr_q <= '0;
      far_q <= '0;
    end else begin
      fsr_q <= fsr_d;
      if (upd_i) far_q <= vaddr_i & PAGE_MASK;
    end
  end

  assign fsr_o = fsr_q;
  assign far_o = far_q;

  p_no_overflow_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && (rd_i || fsr_q == '0)) |=> (fsr_q[FSR_VLD] && !fsr_q[FSR_OVF]));

  p_overflow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !rd_i && fsr_q != '0) |=> fsr_q[FSR_OVF]);

  p_rd_clear_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !upd_i) |=> (fsr_q == '0));

  p_far_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> (far_q[PAGE_BITS-1:0] == '0 &&
               far_q[ADDR_W-1:PAGE_BITS] == $past(vaddr_i[ADDR_W-1:PAGE_BITS])));

  p_far_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(far_q));
endmodule

// File: rtl/mmu_access_guard.sv
`timescale 1ns/1ps
module mmu_access_guard
  import mmu_acc_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              acc_write_i,
  input  logic              acc_fetch_i,
  input  logic              acc_super_i,
  input  logic [2:0]        perm_code_i,
  input  logic              modified_i,
  input  logic [ADDR_W-1:0] vaddr_i,
  input  logic              no_fault_i,
  input  logic              traps_en_i,
  input  logic              fsr_rd_i,
  output logic              grant_o,
  output logic [2:0]        perm_o,
  output logic              trap_inst_o,
  output logic              trap_data_o,
  output logic [7:0]        fsr_o,
  output logic [ADDR_W-1:0] far_o
);
  acc_idx_t   idx;
  logic [3:0] err;
  logic [2:0] rights;
  logic       upd;

  assign idx = '{write: acc_write_i, fetch: acc_fetch_i, sup: acc_super_i};

  acc_perm_decode #(.CODE_W(3)) u_dec (
    .idx_i    (idx),
    .code_i   (perm_code_i),
    .err_o    (err),
    .rights_o (rights)
  );

  acc_fault_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .idx_i       (idx),
    .err_i       (err),
    .rights_i    (rights),
    .modified_i  (modified_i),
    .no_fault_i  (no_fault_i),
    .traps_en_i  (traps_en_i),
    .upd_o       (upd),
    .grant_o     (grant_o),
    .perm_o      (perm_o),
    .trap_inst_o (trap_inst_o),
    .trap_data_o (trap_data_o)
  );

  acc_fault_regs #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .upd_i   (upd),
    .rd_i    (fsr_rd_i),
    .idx_i   (idx),
    .err_i   (err),
    .vaddr_i (vaddr_i),
    .fsr_o   (fsr_o),
    .far_o   (far_o)
  );

  p_priv_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!acc_super_i && perm_code_i[2:1] == 2'b11) |-> (err == ERR_PRIV));

  p_idle_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |-> (!grant_o && perm_o == 3'b000 && !trap_inst_o && !trap_data_o));

  p_idle_regs_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_valid_i && !fsr_rd_i) |=> ($stable(fsr_o) && $stable(far_o)));
endmodule

// File: tb/sim_mmu_access_guard.sv
`timescale 1ns/1ps
module sim_mmu_access_guard;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        rv = 0, wr = 0, fe = 0, su = 0, md = 0, nf = 0, te = 0, rd = 0;
  logic [2:0]  code = 0;
  logic [31:0] va = 0;
  logic        grant, ti, td;
  logic [2:0]  perm;
  logic [7:0]  fsr;
  logic [31:0] far;

  mmu_access_guard u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(rv), .acc_write_i(wr),
    .acc_fetch_i(fe), .acc_super_i(su), .perm_code_i(code), .modified_i(md),
    .vaddr_i(va), .no_fault_i(nf), .traps_en_i(te), .fsr_rd_i(rd),
    .grant_o(grant), .perm_o(perm), .trap_inst_o(ti), .trap_data_o(td),
    .fsr_o(fsr), .far_o(far)
  );

  int total = 0, fails = 0;
  logic [7:0]  m_fsr = 0;
  logic [31:0] m_far = 0;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] rights(input logic [2:0] c, input logic s);
    case (c)
      3'd0: return 3'b001;
      3'd1: return 3'b011;
      3'd2: return 3'b101;
      3'd3: return 3'b111;
      3'd4: return 3'b100;
      3'd5: return s ? 3'b011 : 3'b001;
      3'd6: return s ? 3'b101 : 3'b000;
      default: return s ? 3'b111 : 3'b000;
    endcase
  endfunction

  function automatic logic [3:0] err_of(input logic [2:0] ix, input logic [2:0] c);
    logic [2:0] need;
    if (!ix[0] && c >= 3'd6) return 4'd12;
    need = {ix[1], ix[2], !ix[2] && !ix[1]};
    if ((need & ~rights(c, ix[0])) != 0) return 4'd8;
    return 4'd0;
  endfunction

  task automatic step(input logic v, input logic [2:0] ix, input logic [2:0] c,
                      input logic m, input logic n, input logic t, input logic r,
                      input logic [31:0] a);
    logic [3:0] e;
    logic upd, ovr, trp, eg;
    logic [2:0] ep, rt;
    logic [7:0] base;
    @(negedge clk);
    rv = v; wr = ix[2]; fe = ix[1]; su = ix[0]; code = c; md = m;
    nf = n; te = t; rd = r; va = a;
    #1;
    e   = err_of(ix, c);
    upd = v && e != 0 && !(n && !ix[0]);
    ovr = upd && (n || !t);
    trp = upd && !ovr;
    eg  = v && !trp;
    rt  = rights(c, ix[0]);
    rt[1] = rt[1] & m;
    ep  = !eg ? 3'b000 : (ovr ? 3'b111 : rt);
    check("R2 R10 R13 grant", {63'd0, grant}, {63'd0, eg});
    check("R4 R5 R8 R9 perm", {61'd0, perm}, {61'd0, ep});
    check("R10 trap_inst", {63'd0, ti}, {63'd0, trp && ix[1]});
    check("R10 trap_data", {63'd0, td}, {63'd0, trp && !ix[1]});
    @(posedge clk);
    #1;
    base = r ? 8'd0 : m_fsr;
    if (upd) begin
      m_fsr = {ix, 1'b0, e[3:2], 1'b1, base != 0};
      m_far = a & 32'hFFFF_F000;
    end else begin
      m_fsr = base;
    end
    check("R6 R11 fsr", {56'd0, fsr}, {56'd0, m_fsr});
    check("R7 far", {32'd0, far}, {32'd0, m_far});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R12 fsr reset", {56'd0, fsr}, 64'd0);
    check("R12 far reset", {32'd0, far}, 64'd0);
    rst_n = 1'b1;

    // R13: idle cycle with faulting attributes
    step(0, 3'b010, 3'd7, 0, 0, 1, 0, 32'h1234_5678);
    check("R13 fsr idle", {56'd0, fsr}, 64'd0);

    // R1: supervisor write to read-only page, index 5
    step(1, 3'b101, 3'd0, 1, 0, 1, 1, 32'hDEAD_BEEF);
    check("R1 index field", {61'd0, fsr[7:5]}, 64'd5);
    check("R1 fsr value", {56'd0, fsr}, 64'hAA);
    check("R7 far page", {32'd0, far}, 64'hDEAD_B000);

    // R3: user fetch under code 7, read on same cycle
    step(1, 3'b010, 3'd7, 1, 0, 1, 1, 32'h0000_3FFF);
    check("R3 privilege fsr", {56'd0, fsr}, 64'h4E);

    // R6: unread fault sets overflow
    step(1, 3'b010, 3'd7, 1, 0, 1, 0, 32'h0000_4000);
    check("R6 overflow", {56'd0, fsr}, 64'h4F);

    // R11: fault on a read cycle carries no overflow
    step(1, 3'b010, 3'd6, 1, 0, 1, 1, 32'h0000_5000);
    check("R11 collision", {56'd0, fsr}, 64'h4E);

    // R11: plain read clears
    step(0, 3'b000, 3'd0, 0, 0, 1, 1, 32'h0);
    check("R11 clear", {56'd0, fsr}, 64'd0);

    // R9: user error in no-fault mode leaves registers alone
    step(1, 3'b100, 3'd0, 0, 1, 1, 0, 32'hFFFF_FFFF);
    check("R9 fsr untouched", {56'd0, fsr}, 64'd0);
    check("R9 far untouched", {32'd0, far}, 64'h0000_5000);

    // R8: supervisor fault with traps disabled
    step(1, 3'b001, 3'd4, 0, 0, 0, 0, 32'h8000_1000);
    check("R8 recorded", {56'd0, fsr}, 64'h2A);

    // sweep: index, code, modified, no-fault, trap enable; read every third step
    for (int n = 0; n < 512; n++) begin
      step(1, n[2:0], n[5:3], n[6], n[7], n[8], (n % 3) == 0,
           32'h9E37_79B9 * (n + 1));
    end
    for (int n = 0; n < 8; n++) begin
      step(0, n[2:0], 3'd7, 1, 0, 1, n[0], 32'h5555_0000 + n);
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule